// File: doc/BRIEF.md
# Sample-and-Hold Strobe and Polarity Timing Generator

This block times a six-channel sample-and-hold front end that feeds a three-panel liquid crystal display. During each active pixel of each active line it raises one of six sample strobes, in turn from the first channel to the sixth. The two re-sample strobes fire in the same cycle as the sixth strobe. That shared pulse moves the six held values to the panel drivers at once, so the panel runs at one sixth of the pixel rate. The strobe cycle restarts at the first active pixel of every line. No strobe fires in horizontal or vertical blanking.

The block also drives the polarity select that steers the video between the normal and the inverted amplifier. The select flips on every line and takes one extra flip at each frame start. Two scan-direction levels are passed on to the panel, one horizontal and one vertical. Each is taken from a configuration input at the frame start and held for the rest of the frame. hsync and vsync are active-high and synchronous to the pixel clock. Their rising edges mark line and frame starts.

Top module: `lcd_sh_timing`

## Requirements
- R1: Edge 0 is the rising clock edge that first samples hsync high. On an active line, in the cycle after edge k with H_START <= k < H_START+H_ACTIVE, exactly one strobe is high: sh_o bit ((k-H_START) mod CHANNELS). Bit 0 is the first channel.
- R2: Each strobe is high for one clock only. A line whose active width is not a multiple of CHANNELS ends on a partial group, and the next active line restarts at bit 0.
- R3: sh_o and rs_o are all zero in every cycle outside the horizontal window given in R1.
- R4: The line index is the number of hsync rising edges since the last vsync rising edge. An hsync edge in the same clock as the vsync edge has index 0. sh_o and rs_o stay zero on lines whose index is outside V_START to V_START+V_ACTIVE-1, and on all lines before the first vsync.
- R5: Both bits of rs_o are high in exactly the cycles in which sh_o bit CHANNELS-1 is high.
- R6: pol_inv_o (0 = normal path, 1 = inverted path) changes in the cycle after each hsync rising edge that has no vsync edge with it. It is stable at all other times except frame starts.
- R7: At a vsync rising edge the per-line parity restarts and the frame parity flips. As a result, the first line of each frame has the opposite polarity to the first line of the frame before it.
- R8: After reset, sh_o and rs_o are 0, pol_inv_o is 0 and both direction levels are 1. The strobes stay quiet until a frame has started.
- R9: hdir_o is 1 for normal and 0 for reversed scan, taken as the inverse of cfg_h_rev_i at a vsync rising edge. A change of cfg_h_rev_i mid-frame has no effect on hdir_o until the next vsync edge.
- R10: vdir_o follows the same rule as R9, using cfg_v_rev_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync; rising edge starts a line |
| vsync_i | input | 1 | Vertical sync; rising edge starts a frame |
| cfg_h_rev_i | input | 1 | 1 requests reversed horizontal scan |
| cfg_v_rev_i | input | 1 | 1 requests reversed vertical scan |
| sh_o | output | CHANNELS | Sample strobes, bit 0 = first channel |
| rs_o | output | RS_COUNT | Re-sample strobes, all coincident |
| pol_inv_o | output | 1 | Polarity select, 1 = inverted path |
| hdir_o | output | 1 | Horizontal direction level, 1 = normal |
| vdir_o | output | 1 | Vertical direction level, 1 = normal |

## Verification
The bench uses an active width of 14, which is not a multiple of six. Every line therefore ends on a partial group. A sequencer that carried its phase across lines would start the next line on the wrong channel, and one that ran past the window would strobe into blanking. Lines just before and just after the vertical window are checked cycle by cycle, because an off-by-one in the line index shows up there as a stray row of strobes or a missing one. Polarity is checked at the start of every line, including the line that shares its edge with vsync. A design that toggled on that edge as well, or that did not reset the line parity, gives the same polarity on the first line of two frames in a row. The direction configuration is changed mid-frame, so a design that passed it straight through would change the panel levels one frame early.

// File: rtl/lcd_sh_pkg.sv
package lcd_sh_pkg;

  typedef struct packed {
    logic hs;
    logic vs;
  } sync_ev_t;

  // True when v falls in [lo, lo+len).
  function automatic logic in_window(input int unsigned v,
                                     input int unsigned lo,
                                     input int unsigned len);
    return (v >= lo) && (v < lo + len);
  endfunction

  // Modulo-n increment used for the channel phase.
  function automatic int unsigned wrap_inc(input int unsigned v,
                                           input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // Channel idx is selected when the phase equals its index.
  function automatic logic phase_hit(input int unsigned ph,
                                     input int unsigned idx);
    return ph == idx;
  endfunction

endpackage

// File: rtl/lcd_sh_edge.sv
module lcd_sh_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/lcd_sh_raster.sv
module lcd_sh_raster
  import lcd_sh_pkg::*;
#(
  parameter int CHANNELS = 6,
  parameter int H_START  = 16,
  parameter int H_ACTIVE = 96,
  parameter int V_START  = 4,
  parameter int V_ACTIVE = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  sync_ev_t                    ev_i,
  output logic                        act_o,
  output logic [$clog2(CHANNELS)-1:0] ph_o
);
  localparam int H_END = H_START + H_ACTIVE;
  localparam int V_END = V_START + V_ACTIVE;
  localparam int HW    = $clog2(H_END + 1);
  localparam int VW    = $clog2(V_END + 1);
  localparam int PW    = $clog2(CHANNELS);
  localparam logic [HW-1:0] H_SAT = HW'(H_END);
  localparam logic [VW-1:0] V_SAT = VW'(V_END);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] lcnt;
  logic [PW-1:0] ph;
  logic          h_act, v_act;

  assign h_act = in_window(32'(hcnt), H_START, H_ACTIVE);
  assign v_act = in_window(32'(lcnt), V_START, V_ACTIVE);
  assign act_o = h_act & v_act;
  assign ph_o  = ph;

  // Pixel position since the last line start; saturates in blanking.
  always_ff @(posedge clk) begin
    if (!rst_n)              hcnt <= H_SAT;
    else if (ev_i.hs)        hcnt <= '0;
    else if (hcnt != H_SAT)  hcnt <= hcnt + 1'b1;
  end

  // Line index since the frame start; frame edge wins on a tie.
  always_ff @(posedge clk) begin
    if (!rst_n)                          lcnt <= V_SAT;
    else if (ev_i.vs)                    lcnt <= '0;
    else if (ev_i.hs && lcnt != V_SAT)   lcnt <= lcnt + 1'b1;
  end

  // Channel phase restarts at each line, advances on active pixels only.
  always_ff @(posedge clk) begin
    if (!rst_n)        ph <= '0;
    else if (ev_i.hs)  ph <= '0;
    else if (act_o)    ph <= PW'(wrap_inc(32'(ph), CHANNELS));
  end
endmodule

// File: rtl/lcd_sh_strobe.sv
module lcd_sh_strobe
  import lcd_sh_pkg::*;
#(
  parameter int CHANNELS = 6,
  parameter int RS_COUNT = 2
) (
  input  logic                        act_i,
  input  logic [$clog2(CHANNELS)-1:0] ph_i,
  output logic [CHANNELS-1:0]         sh_o,
  output logic [RS_COUNT-1:0]         rs_o
);
  for (genvar i = 0; i < CHANNELS; i++) begin : g_sh
    assign sh_o[i] = act_i & phase_hit(32'(ph_i), i);
  end

  for (genvar r = 0; r < RS_COUNT; r++) begin : g_rs
    assign rs_o[r] = act_i & phase_hit(32'(ph_i), CHANNELS - 1);
  end
endmodule

// File: rtl/lcd_sh_polarity.sv
module lcd_sh_polarity (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_rise_i,
  input  logic vs_rise_i,
  input  logic cfg_h_rev_i,
  input  logic cfg_v_rev_i,
  output logic pol_inv_o,
  output logic hdir_o,
  output logic vdir_o
);
  logic line_par, frame_par, hdir_q, vdir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_par  <= 1'b0;
      frame_par <= 1'b0;
      hdir_q    <= 1'b1;
      vdir_q    <= 1'b1;
    end else if (vs_rise_i) begin
      line_par  <= 1'b0;
      frame_par <= ~frame_par;
      hdir_q    <= ~cfg_h_rev_i;
      vdir_q    <= ~cfg_v_rev_i;
    end else if (hs_rise_i) begin
      line_par  <= ~line_par;
    end
  end

  assign pol_inv_o = line_par ^ frame_par;
  assign hdir_o    = hdir_q;
  assign vdir_o    = vdir_q;
endmodule

// File: rtl/lcd_sh_timing.sv
module lcd_sh_timing
  import lcd_sh_pkg::*;
#(
  parameter int CHANNELS = 6,
  parameter int RS_COUNT = 2,
  parameter int H_START  = 16,
  parameter int H_ACTIVE = 96,
  parameter int V_START  = 4,
  parameter int V_ACTIVE = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hsync_i,
  input  logic                vsync_i,
  input  logic                cfg_h_rev_i,
  input  logic                cfg_v_rev_i,
  output logic [CHANNELS-1:0] sh_o,
  output logic [RS_COUNT-1:0] rs_o,
  output logic                pol_inv_o,
  output logic                hdir_o,
  output logic                vdir_o
);
  localparam int PW = $clog2(CHANNELS);

  logic [1:0]    sync_vec, rise_vec;
  sync_ev_t      ev;
  logic          hs_rise_w, vs_rise_w, pix_act_w;
  logic [PW-1:0] ph_w;

  assign sync_vec = {vsync_i, hsync_i};

  for (genvar s = 0; s < 2; s++) begin : g_edge
    lcd_sh_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (sync_vec[s]),
      .rise_o(rise_vec[s])
    );
  end

  assign ev.hs     = rise_vec[0];
  assign ev.vs     = rise_vec[1];
  assign hs_rise_w = ev.hs;
  assign vs_rise_w = ev.vs;

  lcd_sh_raster #(
    .CHANNELS(CHANNELS), .H_START(H_START), .H_ACTIVE(H_ACTIVE),
    .V_START(V_START), .V_ACTIVE(V_ACTIVE)
  ) u_raster (
    .clk  (clk),
    .rst_n(rst_n),
    .ev_i (ev),
    .act_o(pix_act_w),
    .ph_o (ph_w)
  );

  lcd_sh_strobe #(.CHANNELS(CHANNELS), .RS_COUNT(RS_COUNT)) u_strobe (
    .act_i(pix_act_w),
    .ph_i (ph_w),
    .sh_o (sh_o),
    .rs_o (rs_o)
  );

  lcd_sh_polarity u_pol (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_rise_i  (hs_rise_w),
    .vs_rise_i  (vs_rise_w),
    .cfg_h_rev_i(cfg_h_rev_i),
    .cfg_v_rev_i(cfg_v_rev_i),
    .pol_inv_o  (pol_inv_o),
    .hdir_o     (hdir_o),
    .vdir_o     (vdir_o)
  );
endmodule

// File: rtl/lcd_sh_timing_chk.sv
module lcd_sh_timing_chk #(
  parameter int CHANNELS = 6,
  parameter int RS_COUNT = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hs_rise,
  input logic                vs_rise,
  input logic                pix_act,
  input logic                cfg_h_rev_i,
  input logic                cfg_v_rev_i,
  input logic [CHANNELS-1:0] sh_o,
  input logic [RS_COUNT-1:0] rs_o,
  input logic                pol_inv_o,
  input logic                hdir_o,
  input logic                vdir_o
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sh_o));

  for (genvar i = 0; i < CHANNELS - 1; i++) begin : g_seq
    p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_o[i] && !hs_rise) |=> (sh_o[i+1] || sh_o == '0));
  end

  for (genvar i = 0; i < CHANNELS; i++) begin : g_wid
    p_one_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_o[i] && !hs_rise) |=> !sh_o[i]);
  end

  p_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_act |-> (sh_o == '0 && rs_o == '0));

  p_resample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_o == {RS_COUNT{sh_o[CHANNELS-1]}}));

  p_pol_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise && !vs_rise) |=> (pol_inv_o != $past(pol_inv_o)));

  p_pol_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_rise && !vs_rise) |=> $stable(pol_inv_o));

  p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> ($stable(hdir_o) && $stable(vdir_o)));

  p_dir_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (hdir_o == !$past(cfg_h_rev_i)));

  p_dir_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (vdir_o == !$past(cfg_v_rev_i)));
endmodule

bind lcd_sh_timing lcd_sh_timing_chk #(
  .CHANNELS(CHANNELS), .RS_COUNT(RS_COUNT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hs_rise    (hs_rise_w),
  .vs_rise    (vs_rise_w),
  .pix_act    (pix_act_w),
  .cfg_h_rev_i(cfg_h_rev_i),
  .cfg_v_rev_i(cfg_v_rev_i),
  .sh_o       (sh_o),
  .rs_o       (rs_o),
  .pol_inv_o  (pol_inv_o),
  .hdir_o     (hdir_o),
  .vdir_o     (vdir_o)
);

// File: tb/tb_lcd_sh_timing.sv
module tb_lcd_sh_timing;
  localparam int CH  = 6;
  localparam int RSN = 2;
  localparam int HS  = 3;
  localparam int HA  = 14;
  localparam int VS  = 2;
  localparam int VA  = 3;
  localparam int LINE_LEN = HS + HA + 5;
  localparam int FRAME_LINES = VS + VA + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0;
  logic cfg_h = 1'b0, cfg_v = 1'b0;
  logic [CH-1:0]  sh;
  logic [RSN-1:0] rs;
  logic pol, hdir, vdir;

  int n_chk = 0, n_fail = 0;
  int lidx = 1000;
  bit line_par = 0, frame_par = 0;
  bit exp_h = 1, exp_v = 1;
  bit timed_out = 0;

  always #5 clk = ~clk;

  lcd_sh_timing #(
    .CHANNELS(CH), .RS_COUNT(RSN), .H_START(HS), .H_ACTIVE(HA),
    .V_START(VS), .V_ACTIVE(VA)
  ) dut (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
    .cfg_h_rev_i(cfg_h), .cfg_v_rev_i(cfg_v),
    .sh_o(sh), .rs_o(rs), .pol_inv_o(pol), .hdir_o(hdir), .vdir_o(vdir)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One line: hsync rises at the first edge; vs selects a frame start.
  task automatic do_line(input bit vs);
    @(negedge clk);
    hsync = 1'b1;
    if (vs) vsync = 1'b1;
    if (vs) begin
      lidx = 0; frame_par = ~frame_par; line_par = 0;
      exp_h = ~cfg_h; exp_v = ~cfg_v;
    end else begin
      lidx++; line_par = ~line_par;
    end
    for (int j = 1; j < LINE_LEN; j++) begin
      int k;
      bit hwin, vwin;
      logic [CH-1:0]  e_sh;
      logic [RSN-1:0] e_rs;
      @(negedge clk);
      k = j - 1;
      hwin = (k >= HS) && (k < HS + HA);
      vwin = (lidx >= VS) && (lidx < VS + VA);
      e_sh = '0; e_rs = '0;
      if (hwin && vwin) begin
        e_sh[(k - HS) % CH] = 1'b1;
        if ((k - HS) % CH == CH - 1) e_rs = '1;
      end
      if (!vwin)       chk("R4 strobes outside vertical window", 32'(sh), 32'(e_sh));
      else if (!hwin)  chk("R3 strobes outside horizontal window", 32'(sh), 32'(e_sh));
      else if (k - HS < CH) chk("R2 group restart at line start", 32'(sh), 32'(e_sh));
      else             chk("R1 strobe order", 32'(sh), 32'(e_sh));
      chk("R5 re-sample with last channel", 32'(rs), 32'(e_rs));
      if (j == 1 || j == LINE_LEN - 1)
        chk(vs ? "R7 polarity at frame start" : "R6 polarity per line",
            32'(pol), 32'(line_par ^ frame_par));
      if (j == 1) begin
        chk("R9 horizontal direction level", 32'(hdir), 32'(exp_h));
        chk("R10 vertical direction level", 32'(vdir), 32'(exp_v));
      end
      if (j == 2) hsync = 1'b0;
      if (j == 3) vsync = 1'b0;
    end
  endtask

  task automatic do_frame(input bit flip_h, input bit flip_v);
    do_line(1'b1);
    for (int l = 1; l < FRAME_LINES; l++) begin
      if (l == VS) begin
        if (flip_h) cfg_h = ~cfg_h;
        if (flip_v) cfg_v = ~cfg_v;
      end
      do_line(1'b0);
    end
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    chk("R8 reset strobes", 32'(sh), 0);
    chk("R8 reset re-sample", 32'(rs), 0);
    chk("R8 reset polarity", 32'(pol), 0);
    chk("R8 reset direction levels", 32'({hdir, vdir}), 32'h3);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 quiet after reset", 32'(sh), 0);
    // Lines before any frame start: no strobes, polarity still toggles.
    do_line(1'b0);
    do_line(1'b0);
    // Mid-frame changes of the direction settings take effect next frame.
    do_frame(1'b1, 1'b1);
    do_frame(1'b1, 1'b0);
    do_frame(1'b0, 1'b1);
    do_frame(1'b0, 1'b0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule